// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering

This block sits between a queue of pre-classified instruction descriptors and a micro-op queue. Each descriptor gives a sequence tag, a micro-op count and a flag that says whether the instruction is simple. Each cycle the block looks at the three oldest descriptors and decides, in program order, how many of them it decodes. The block has one general slot and two restricted slots. The general slot takes the oldest descriptor and emits up to four micro-ops for it. The two restricted slots take the next two descriptors, and each of them emits exactly one micro-op. An instruction that needs more than four micro-ops goes to a sequencer. The sequencer emits that instruction's micro-ops over several cycles, and no other instruction is decoded while it runs.

Micro-ops leave on six output lanes. Each lane carries the instruction's tag, the micro-op's index within the instruction, and a flag that marks the final micro-op. The downstream queue reports each cycle how many entries it can accept. The block decodes only the in-order prefix of whole instructions whose micro-ops fit in that space. A flush input drops every held descriptor and aborts the sequencer. The descriptor queue is inside the block and has a single push port. Every descriptor is expected to carry a micro-op count of at least one. Memory-accessing instructions must arrive with the simple flag cleared.

Top module: `uop_steer`

## Requirements
- R1: While reset is applied and in the first cycles after it is released, no output lane is valid and `in_ready` is high (the queue is empty).
- R2: If the sequencer is idle and the oldest descriptor has a count n of 1 to 4, then when `room` is at least n, all n micro-ops are emitted in the same cycle on lanes 0 to n-1. They carry indices 0 to n-1, and `last` is set only on index n-1.
- R3: The second and third oldest descriptors are decoded in the same cycle as the oldest one only if the oldest one is fully decoded, their simple flag is 1 and their count is exactly 1. Each of them uses the next free lane, with index 0 and `last` set to 1.
- R4: Decode stops in order. If the second descriptor is not eligible for a restricted slot, the third descriptor is not decoded in that cycle, even if it is eligible.
- R5: The number of valid lanes never exceeds `room`. An instruction of 1 to 4 micro-ops is emitted whole or not at all. If it does not fit, nothing is emitted in that cycle.
- R6: If no flush is active, the sequencer is idle, the queue is not empty, the oldest descriptor has a count of 4 or fewer, and `room` covers that count, then at least the oldest descriptor is decoded in that cycle.
- R7: A descriptor with a count above 4 is handled by the sequencer. The sequencer emits min(4, `room`, remaining) micro-ops per cycle with rising indices. No other descriptor is decoded while it runs. The descriptor is released in the cycle its final micro-op, with `last` set, is emitted.
- R8: The valid lanes always form a contiguous run that starts at lane 0.
- R9: In a cycle with `flush` high, no lane is valid and any offered descriptor is dropped. In the next cycle the queue is empty and the sequencer is idle.
- R10: A descriptor is accepted when `in_valid` is high and fewer than DEPTH descriptors are held. `in_ready` is low exactly when DEPTH descriptors are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Drop all held descriptors and abort the sequencer |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Queue has a free entry |
| in_tag | input | TAG_W (6) | Sequence tag of the offered descriptor |
| in_ucnt | input | CNT_W (8) | Micro-op count of the offered descriptor (at least 1) |
| in_simple | input | 1 | 1 when the instruction may use a restricted slot |
| room | input | ROOM_W (3) | Free entries in the downstream micro-op queue this cycle |
| out_valid | output | LANES (6) | Per-lane micro-op valid |
| out_tag | output | LANES*TAG_W | Per-lane tag, lane l in bits [l*TAG_W +: TAG_W] |
| out_idx | output | LANES*CNT_W | Per-lane micro-op index within its instruction |
| out_last | output | LANES | Per-lane final-micro-op marker |

## Verification
The output lanes and `in_ready` are combinational. Each one depends on the registered queue and sequencer state together with the current `room` and `flush`, so the effect of an input on the lanes can be seen in the same cycle. A push, a pop, a flush or a sequencer step first appears in the lanes of the following cycle. The bench drives the inputs on the falling edge and samples one time unit later. At that point it compares against a reference model that is still in its pre-edge state. It then advances the model to match the next rising edge. This keeps the expected values aligned with the cycle in which each result is due.

// File: rtl/uop_steer_pkg.sv
package uop_steer_pkg;
  localparam int TAG_W    = 6;
  localparam int CNT_W    = 8;
  localparam int GEN_UOPS = 4;
  localparam int SLOTS    = 3;
  localparam int LANES    = GEN_UOPS + SLOTS - 1;
  localparam int ROOM_W   = $clog2(LANES + 1);
  localparam int POP_W    = $clog2(SLOTS + 1);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] ucnt;
    logic             simple;
  } desc_t;
endpackage

// File: rtl/us_desc_queue.sv
module us_desc_queue
  import uop_steer_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  push,
  input  desc_t                 push_d,
  input  logic [POP_W-1:0]      pop,
  output desc_t [SLOTS-1:0]     peek,
  output logic  [CW-1:0]        cnt,
  output logic                  ready
);
  desc_t          mem [DEPTH];
  logic [AW-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]  cnt_d;

  always_comb begin
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = rd_q + AW'(pop);
      wr_d  = wr_q + AW'(push);
      cnt_d = cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
      cnt  <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
      cnt  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_d;
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_peek
    assign peek[k] = mem[AW'(rd_q + AW'(k))];
  end

  assign ready = cnt < CW'(DEPTH);

  // R10: held count never exceeds the capacity
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R9: a flush leaves the queue empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == '0);
  // R3: never release more descriptors than are held
  p_pop_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop) <= cnt);
endmodule

// File: rtl/us_seq_state.sv
module us_seq_state
  import uop_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             upd,
  input  logic             act_d,
  input  logic [CNT_W-1:0] idx_d,
  output logic             act,
  output logic [CNT_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
    end else if (flush) begin
      act <= 1'b0;
      idx <= '0;
    end else if (upd) begin
      act <= act_d;
      idx <= idx_d;
    end
  end

  // R9: flush aborts the sequencer
  p_flush_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !act);
  // R7: a continuing sequence moves strictly forward
  p_idx_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !flush && upd && act_d) |=> idx > $past(idx));
endmodule

// File: rtl/us_slot_pick.sv
module us_slot_pick
  import uop_steer_pkg::*;
(
  input  logic                          flush,
  input  logic [ROOM_W-1:0]             room,
  input  logic [SLOTS-1:0]              vld,
  input  desc_t [SLOTS-1:0]             peek,
  input  logic                          seq_act,
  input  logic [CNT_W-1:0]              seq_idx,
  output logic [LANES-1:0]              lv,
  output logic [LANES-1:0][TAG_W-1:0]   lt,
  output logic [LANES-1:0][CNT_W-1:0]   li,
  output logic [LANES-1:0]              ll,
  output logic [POP_W-1:0]              pop,
  output logic                          seq_upd,
  output logic                          seq_act_d,
  output logic [CNT_W-1:0]              seq_idx_d
);
  logic [CNT_W-1:0] base, rem, room_c, cap, g_n, used;
  logic             long_go, head_done;
  logic [SLOTS-1:0] take;

  always_comb begin
    base      = seq_act ? seq_idx : '0;
    rem       = peek[0].ucnt - base;
    long_go   = seq_act || (peek[0].ucnt > CNT_W'(GEN_UOPS));
    room_c    = CNT_W'(room);
    cap       = (room_c < CNT_W'(GEN_UOPS)) ? room_c : CNT_W'(GEN_UOPS);
    g_n       = '0;
    head_done = 1'b0;
    if (!flush && vld[0]) begin
      if (long_go) begin
        g_n       = (rem < cap) ? rem : cap;
        head_done = (g_n == rem);
      end else if (room_c >= peek[0].ucnt) begin
        g_n       = peek[0].ucnt;
        head_done = 1'b1;
      end
    end

    used    = g_n;
    take    = '0;
    take[0] = head_done;
    for (int k = 1; k < SLOTS; k++) begin
      take[k] = take[k-1] && !long_go && vld[k] && peek[k].simple &&
                (peek[k].ucnt == CNT_W'(1)) && (used < room_c);
      if (take[k]) used = used + CNT_W'(1);
    end

    pop = '0;
    for (int k = 0; k < SLOTS; k++) pop = pop + POP_W'(take[k]);

    for (int l = 0; l < LANES; l++) begin
      lv[l] = 1'b0;
      lt[l] = '0;
      li[l] = '0;
      ll[l] = 1'b0;
      if (CNT_W'(l) < g_n) begin
        lv[l] = 1'b1;
        lt[l] = peek[0].tag;
        li[l] = base + CNT_W'(l);
        ll[l] = (base + CNT_W'(l)) == (peek[0].ucnt - CNT_W'(1));
      end else begin
        for (int k = 1; k < SLOTS; k++) begin
          if (take[k] && (CNT_W'(l) == g_n + CNT_W'(k - 1))) begin
            lv[l] = 1'b1;
            lt[l] = peek[k].tag;
            ll[l] = 1'b1;
          end
        end
      end
    end

    seq_upd   = !flush && vld[0] && long_go && (g_n != '0);
    seq_act_d = !head_done;
    seq_idx_d = head_done ? '0 : base + g_n;
  end
endmodule

// File: rtl/uop_steer.sv
module uop_steer
  import uop_steer_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [TAG_W-1:0]        in_tag,
  input  logic [CNT_W-1:0]        in_ucnt,
  input  logic                    in_simple,
  input  logic [ROOM_W-1:0]       room,
  output logic [LANES-1:0]        out_valid,
  output logic [LANES*TAG_W-1:0]  out_tag,
  output logic [LANES*CNT_W-1:0]  out_idx,
  output logic [LANES-1:0]        out_last
);
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  desc_t [SLOTS-1:0]            peek;
  logic  [CW-1:0]               cnt;
  logic  [SLOTS-1:0]            vld;
  logic                         push;
  logic  [POP_W-1:0]            pop;
  logic                         seq_act, seq_upd, seq_act_d;
  logic  [CNT_W-1:0]            seq_idx, seq_idx_d;
  logic  [LANES-1:0][TAG_W-1:0] lt;
  logic  [LANES-1:0][CNT_W-1:0] li;

  assign push = in_valid && in_ready && !flush;

  for (genvar k = 0; k < SLOTS; k++) begin : g_vld
    assign vld[k] = cnt > CW'(k);
  end

  us_desc_queue #(.DEPTH(DEPTH)) i_queue (
    .clk    (clk),
    .rst_n  (rst_i),
    .flush  (flush),
    .push   (push),
    .push_d ('{tag: in_tag, ucnt: in_ucnt, simple: in_simple}),
    .pop    (pop),
    .peek   (peek),
    .cnt    (cnt),
    .ready  (in_ready)
  );

  us_seq_state i_seq (
    .clk   (clk),
    .rst_n (rst_i),
    .flush (flush),
    .upd   (seq_upd),
    .act_d (seq_act_d),
    .idx_d (seq_idx_d),
    .act   (seq_act),
    .idx   (seq_idx)
  );

  us_slot_pick i_pick (
    .flush     (flush),
    .room      (room),
    .vld       (vld),
    .peek      (peek),
    .seq_act   (seq_act),
    .seq_idx   (seq_idx),
    .lv        (out_valid),
    .lt        (lt),
    .li        (li),
    .ll        (out_last),
    .pop       (pop),
    .seq_upd   (seq_upd),
    .seq_act_d (seq_act_d),
    .seq_idx_d (seq_idx_d)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_flat
    assign out_tag[l*TAG_W +: TAG_W] = lt[l];
    assign out_idx[l*CNT_W +: CNT_W] = li[l];
  end

  // R8: valid lanes form a prefix starting at lane 0
  p_lanes_contig_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid & (out_valid + LANES'(1))) == '0);
  // R5: never more micro-ops than the downstream room
  p_room_kept_r5: assert property (@(posedge clk) disable iff (!rst_i)
    $countones(out_valid) <= int'(room));
  // R6: a fitting short head is always decoded
  p_progress_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (!flush && !seq_act && vld[0] && peek[0].ucnt <= CNT_W'(GEN_UOPS) &&
     CNT_W'(room) >= peek[0].ucnt) |-> pop != '0);
  // R7: while sequencing, at most the head is released
  p_seq_alone_r7: assert property (@(posedge clk) disable iff (!rst_i)
    seq_act |-> pop <= POP_W'(1));
  // R9: nothing leaves during a flush
  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_i)
    flush |-> out_valid == '0);
endmodule

// File: tb/test_uop_steer.sv
module test_uop_steer;
  import uop_steer_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int QM         = 1024;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   flush = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic [TAG_W-1:0]       in_tag = '0;
  logic [CNT_W-1:0]       in_ucnt = '0;
  logic                   in_simple = 1'b0;
  logic [ROOM_W-1:0]      room = '0;
  logic [LANES-1:0]       out_valid;
  logic [LANES*TAG_W-1:0] out_tag;
  logic [LANES*CNT_W-1:0] out_idx;
  logic [LANES-1:0]       out_last;

  uop_steer #(.DEPTH(DEPTH)) i_uop_steer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_tag(in_tag), .in_ucnt(in_ucnt),
    .in_simple(in_simple), .room(room), .out_valid(out_valid),
    .out_tag(out_tag), .out_idx(out_idx), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  nchk = 0, nerr = 0, obs_n = 0, tag_ctr = 0;
  bit  done = 1'b0;
  int  q_tag [QM];
  int  q_u   [QM];
  bit  q_s   [QM];
  int  qh = 0, qt = 0, m_idx = 0;
  bit  m_seq = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int min3(input int a, input int b, input int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  task automatic step(input bit fl, input bit pv, input int uc,
                      input bit sp, input int rm);
    int n, e_n, pop, h, u0, base, rem, k;
    int e_tag [LANES];
    int e_idx [LANES];
    bit e_last [LANES];
    string e_req [LANES];
    @(negedge clk);
    flush = fl; in_valid = pv; in_tag = TAG_W'(tag_ctr);
    in_ucnt = CNT_W'(uc); in_simple = sp; room = ROOM_W'(rm);
    #1;
    n = qt - qh; e_n = 0; pop = 0;
    if (!fl && n > 0) begin
      h = qh % QM; u0 = q_u[h];
      if (m_seq || u0 > GEN_UOPS) begin
        base = m_seq ? m_idx : 0;
        rem  = u0 - base;
        k    = min3(GEN_UOPS, rem, rm);
        for (int j = 0; j < k; j++) begin
          e_tag[e_n] = q_tag[h]; e_idx[e_n] = base + j;
          e_last[e_n] = (base + j == u0 - 1); e_req[e_n] = "R7"; e_n++;
        end
        if (k == rem) begin pop = 1; m_seq = 0; m_idx = 0; end
        else if (k > 0) begin m_seq = 1; m_idx = base + k; end
      end else if (rm >= u0) begin
        for (int j = 0; j < u0; j++) begin
          e_tag[e_n] = q_tag[h]; e_idx[e_n] = j;
          e_last[e_n] = (j == u0 - 1); e_req[e_n] = "R2"; e_n++;
        end
        pop = 1;
        for (int s = 1; s < SLOTS; s++) begin
          int hs = (qh + s) % QM;
          if (n > s && q_s[hs] && q_u[hs] == 1 && e_n < rm) begin
            e_tag[e_n] = q_tag[hs]; e_idx[e_n] = 0; e_last[e_n] = 1;
            e_req[e_n] = "R3"; e_n++; pop++;
          end else break;
        end
      end
    end
    chk("R10 in_ready", int'(in_ready), int'(n < DEPTH));
    obs_n = $countones(out_valid);
    chk("R5 lane count", obs_n, e_n);
    for (int l = 0; l < LANES; l++) begin
      chk("R8 lane valid", int'(out_valid[l]), int'(l < e_n));
      if (l < e_n && out_valid[l])
        chk(e_req[l],
            int'({out_tag[l*TAG_W +: TAG_W], out_idx[l*CNT_W +: CNT_W], out_last[l]}),
            int'({TAG_W'(e_tag[l]), CNT_W'(e_idx[l]), e_last[l]}));
    end
    qh += pop;
    if (fl) begin qh = qt; m_seq = 0; m_idx = 0; end
    else if (pv && n < DEPTH) begin
      q_tag[qt % QM] = tag_ctr % (1 << TAG_W); q_u[qt % QM] = uc;
      q_s[qt % QM] = sp; qt++;
    end
    tag_ctr++;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset ready", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset valid", int'(out_valid), 0);

    // R4: simple, non-simple single, simple -> only head goes
    step(0, 1, 1, 1, 0);
    step(0, 1, 1, 0, 0);
    step(0, 1, 1, 1, 0);
    step(0, 0, 1, 0, 6);
    chk("R4 stop at ineligible", obs_n, 1);
    step(0, 0, 1, 0, 6);
    chk("R4 ineligible at head pairs", obs_n, 2);

    // R7: long instruction then a simple one waiting behind it
    step(0, 1, 10, 0, 0);
    step(0, 1, 1, 1, 0);
    step(0, 0, 1, 0, 6);
    chk("R7 chunk one", obs_n, 4);
    step(0, 0, 1, 0, 6);
    chk("R7 chunk two", obs_n, 4);
    step(0, 0, 1, 0, 6);
    chk("R7 tail alone", obs_n, 2);
    step(0, 0, 1, 0, 6);
    chk("R7 follower after release", obs_n, 1);

    // R5 / R6: three micro-op head with too little room
    step(0, 1, 3, 0, 0);
    step(0, 0, 1, 0, 2);
    chk("R5 no partial", obs_n, 0);
    step(0, 0, 1, 0, 3);
    chk("R6 fits exactly", obs_n, 3);

    // R10 / R9: fill the queue, then flush
    for (int i = 0; i < DEPTH; i++) step(0, 1, 2, 0, 0);
    step(0, 1, 1, 1, 0);
    chk("R10 full not ready", int'(in_ready), 0);
    step(1, 1, 1, 1, 6);
    chk("R9 flush quiet", obs_n, 0);
    step(0, 0, 1, 0, 6);
    chk("R9 empty after flush", obs_n, 0);
    chk("R9 ready after flush", int'(in_ready), 1);

    for (int c = 0; c < 3000; c++) begin
      int r = $urandom_range(0, 99);
      int uc;
      bit sp;
      if (r < 60) uc = 1;
      else if (r < 85) uc = $urandom_range(2, 4);
      else uc = $urandom_range(5, 12);
      sp = (uc == 1) && ($urandom_range(0, 9) < 7);
      step($urandom_range(0, 99) < 2, $urandom_range(0, 9) < 7, uc, sp,
           ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : 6);
    end
    summary();
  end
endmodule